// File: doc/BRIEF.md
# Two-Input Neuron Trainer with Error-Correction Updates

The block trains one linear neuron with two binary inputs and a bias so that its weighted sum approximates a two-input Boolean function. Software or a host sequencer loads starting weights and a bias, chooses the target function, and supplies a learning rate, an error tolerance and an epoch limit. A start pulse then runs training. Each epoch visits the four input patterns. For each pattern the engine forms the weighted sum, takes the error against the target, and moves every weight and the bias along the error.

Training ends in one of two ways. The first is an epoch in which every pattern's absolute error stayed below the tolerance, which raises a converged flag. The second is the epoch limit, which raises a timeout flag. After either, the trained weights stay frozen at the outputs, next to the number of epochs and clock cycles that training took. All arithmetic is signed fixed point with 12 fractional bits in a 16-bit word, so 1.0 is 4096.

Top module: `lms_neuron_trainer`

## Requirements
- R1: After reset, done, converged and timeout are low, and the three weight outputs, epochCount and cycleCount are all zero.
- R2: In idle, with done either high or low, a loadW pulse copies w0Init, w1Init and biasInit into the weights, which are visible on the outputs one cycle later. While training runs, loadW, start and changes to funcSel have no effect.
- R3: Patterns run in the order index 0, 1, 2, 3. Input x0 is index bit 1 and x1 is index bit 0. The sum is bias + x0*w0 + x1*w1, saturated to 16 bits. The target is 1.0 only at index 3 when funcSel is 0 (AND), and 1.0 at every index except 0 when funcSel is 1 (OR); otherwise it is 0. The error is the target minus the sum, saturated.
- R4: For each pattern, delta is learnRate times error, rounded by adding 2048 and shifting right arithmetically by 12, then saturated to 16 bits. The delta is added with saturation to w0 when x0 is 1, to w1 when x1 is 1, and always to the bias.
- R5: If every one of an epoch's four errors has an absolute value strictly below tolerance, training ends after that epoch. Done and converged go high, and epochCount holds the number of epochs run.
- R6: An epoch that does not converge, and that brings the epoch count up to maxEpochs, ends training with done and timeout high. A maxEpochs of 0 acts as 1.
- R7: When convergence and the epoch limit fall on the same epoch, converged is raised and timeout stays low. The two flags are never high together.
- R8: When done rises, cycleCount equals 13 times epochCount: three cycles per pattern plus one cycle for the epoch check.
- R9: Once done is high, it stays high and the weights stay unchanged until the next start or loadW.
- R10: A start pulse in idle clears done, the flags and both counters, and resumes training from the weights currently held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin training (idle only) |
| loadW | input | 1 | Load initial weights and bias (idle only) |
| funcSel | input | 1 | Target function: 0 AND, 1 OR; sampled at start |
| w0Init | input | 16 | Initial weight for x0, Q4.12 |
| w1Init | input | 16 | Initial weight for x1, Q4.12 |
| biasInit | input | 16 | Initial bias, Q4.12 |
| learnRate | input | 16 | Learning rate, Q4.12 |
| tolerance | input | 16 | Absolute error bound, Q4.12 |
| maxEpochs | input | 12 | Epoch limit |
| done | output | 1 | Training finished |
| converged | output | 1 | Finished by convergence |
| timeout | output | 1 | Finished by epoch limit |
| w0Out | output | 16 | Current weight w0 |
| w1Out | output | 16 | Current weight w1 |
| biasOut | output | 16 | Current bias |
| epochCount | output | 12 | Epochs run in the last training |
| cycleCount | output | 16 | Clock cycles of the last training |

## Verification
The convergence test and the epoch-limit test are made in the same end-of-epoch cycle. They collide when the tolerance is met in exactly the epoch that reaches maxEpochs. The bench provokes this with a tolerance so wide that the first epoch converges and an epoch limit of one. It expects converged high and timeout low, with epoch and cycle counts of 1 and 13. It also runs the opposite case, a zero tolerance, where the same limit must give a timeout.

// File: rtl/lms_neuron_pkg.sv
package lms_neuron_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAC,
    ST_ERR,
    ST_UPD,
    ST_CHECK
  } trainState_t;

  // Strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic       loadInit;
    logic       latchSum;
    logic       latchErr;
    logic       applyUpd;
    logic [1:0] patIdx;
    logic       funcOr;
  } dpCtrl_t;

  localparam int unsigned PATTERN_COUNT    = 4;
  localparam int unsigned STEPS_PER_PAT    = 3;
  localparam int unsigned CYCLES_PER_EPOCH = PATTERN_COUNT * STEPS_PER_PAT + 1;

endpackage

// File: rtl/lms_neuron_dp.sv
module lms_neuron_dp
  import lms_neuron_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtrl_t                  ctl,
  input  logic signed [DATA_W-1:0] w0Init,
  input  logic signed [DATA_W-1:0] w1Init,
  input  logic signed [DATA_W-1:0] biasInit,
  input  logic signed [DATA_W-1:0] learnRate,
  input  logic signed [DATA_W-1:0] tolerance,
  output logic signed [DATA_W-1:0] w0,
  output logic signed [DATA_W-1:0] w1,
  output logic signed [DATA_W-1:0] bias,
  output logic                     errOk
);

  localparam int SUM_W  = DATA_W + 2;
  localparam int PROD_W = 2 * DATA_W;
  localparam int ABS_W  = DATA_W + 1;

  localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [PROD_W-1:0] SAT_LO = ~SAT_HI;
  localparam logic signed [PROD_W-1:0] RND_HALF = PROD_W'(64'sd1 <<< (FRAC_W - 1));
  localparam logic signed [SUM_W-1:0]  ONE_Q = SUM_W'(64'sd1 <<< FRAC_W);
  localparam logic signed [SUM_W-1:0]  ZERO_Q = '0;

  function automatic logic signed [DATA_W-1:0] satNarrow(input logic signed [PROD_W-1:0] v);
    if (v > SAT_HI) begin
      return SAT_HI[DATA_W-1:0];
    end else if (v < SAT_LO) begin
      return SAT_LO[DATA_W-1:0];
    end else begin
      return v[DATA_W-1:0];
    end
  endfunction

  logic signed [DATA_W-1:0] w0Reg, w1Reg, biasReg, sumReg, errReg;
  logic signed [SUM_W-1:0]  sumWide, errWide, targetVal;
  logic signed [PROD_W-1:0] prodFull, prodRnd;
  logic signed [DATA_W-1:0] delta, w0Next, w1Next, biasNext;
  logic signed [ABS_W-1:0]  errExt, errAbs;
  logic                     x0, x1, tgtBit;

  assign x0 = ctl.patIdx[1];
  assign x1 = ctl.patIdx[0];
  assign tgtBit = ctl.funcOr ? (|ctl.patIdx) : (&ctl.patIdx);

  always_comb begin
    sumWide = SUM_W'(biasReg);
    if (x0) sumWide = sumWide + SUM_W'(w0Reg);
    if (x1) sumWide = sumWide + SUM_W'(w1Reg);
    targetVal = tgtBit ? ONE_Q : ZERO_Q;
    errWide   = targetVal - SUM_W'(sumReg);
  end

  always_comb begin
    prodFull = PROD_W'(learnRate) * PROD_W'(errReg);
    prodRnd  = (prodFull + RND_HALF) >>> FRAC_W;
    delta    = satNarrow(prodRnd);
    w0Next   = satNarrow(PROD_W'(w0Reg) + PROD_W'(delta));
    w1Next   = satNarrow(PROD_W'(w1Reg) + PROD_W'(delta));
    biasNext = satNarrow(PROD_W'(biasReg) + PROD_W'(delta));
  end

  always_comb begin
    errExt = ABS_W'(errReg);
    errAbs = (errExt < 0) ? -errExt : errExt;
    errOk  = errAbs < ABS_W'(tolerance);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      w0Reg   <= '0;
      w1Reg   <= '0;
      biasReg <= '0;
      sumReg  <= '0;
      errReg  <= '0;
    end else begin
      if (ctl.loadInit) begin
        w0Reg   <= w0Init;
        w1Reg   <= w1Init;
        biasReg <= biasInit;
      end else if (ctl.applyUpd) begin
        if (x0) w0Reg <= w0Next;
        if (x1) w1Reg <= w1Next;
        biasReg <= biasNext;
      end
      if (ctl.latchSum) sumReg <= satNarrow(PROD_W'(sumWide));
      if (ctl.latchErr) errReg <= satNarrow(PROD_W'(errWide));
    end
  end

  assign w0   = w0Reg;
  assign w1   = w1Reg;
  assign bias = biasReg;

endmodule

// File: rtl/lms_neuron_ctrl.sv
module lms_neuron_ctrl
  import lms_neuron_pkg::*;
#(
  parameter int EPOCH_W = 12,
  parameter int CYC_W   = EPOCH_W + 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               loadW,
  input  logic               funcSel,
  input  logic [EPOCH_W-1:0] maxEpochs,
  input  logic               errOk,
  output dpCtrl_t            ctl,
  output logic               done,
  output logic               converged,
  output logic               timeout,
  output logic [EPOCH_W-1:0] epochCount,
  output logic [CYC_W-1:0]   cycleCount
);

  trainState_t        state;
  logic [1:0]         patIdx;
  logic               funcOrReg, allOk;
  logic               doneReg, convReg, toReg;
  logic [EPOCH_W-1:0] epochReg, epochNext, limitEff;
  logic [CYC_W-1:0]   cycReg;
  logic               isIdle, limitHit, epochOk;

  assign isIdle    = (state == ST_IDLE);
  assign epochNext = epochReg + 1'b1;
  assign limitEff  = (maxEpochs == '0) ? EPOCH_W'(1) : maxEpochs;
  assign limitHit  = (epochNext >= limitEff);
  assign epochOk   = allOk;

  always_comb begin
    ctl          = '0;
    ctl.patIdx   = patIdx;
    ctl.funcOr   = funcOrReg;
    ctl.loadInit = isIdle && loadW;
    ctl.latchSum = (state == ST_MAC);
    ctl.latchErr = (state == ST_ERR);
    ctl.applyUpd = (state == ST_UPD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      patIdx    <= '0;
      funcOrReg <= 1'b0;
      allOk     <= 1'b1;
      doneReg   <= 1'b0;
      convReg   <= 1'b0;
      toReg     <= 1'b0;
      epochReg  <= '0;
      cycReg    <= '0;
    end else begin
      if (!isIdle) cycReg <= cycReg + 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_MAC;
            patIdx    <= '0;
            funcOrReg <= funcSel;
            allOk     <= 1'b1;
            doneReg   <= 1'b0;
            convReg   <= 1'b0;
            toReg     <= 1'b0;
            epochReg  <= '0;
            cycReg    <= '0;
          end
        end
        ST_MAC: state <= ST_ERR;
        ST_ERR: state <= ST_UPD;
        ST_UPD: begin
          allOk  <= allOk && errOk;
          patIdx <= patIdx + 1'b1;
          state  <= (patIdx == 2'd3) ? ST_CHECK : ST_MAC;
        end
        ST_CHECK: begin
          epochReg <= epochNext;
          allOk    <= 1'b1;
          if (epochOk) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
            convReg <= 1'b1;
          end else if (limitHit) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
            toReg   <= 1'b1;
          end else begin
            state <= ST_MAC;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done       = doneReg;
  assign converged  = convReg;
  assign timeout    = toReg;
  assign epochCount = epochReg;
  assign cycleCount = cycReg;

endmodule

// File: rtl/lms_neuron_trainer.sv
module lms_neuron_trainer
  import lms_neuron_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FRAC_W  = 12,
  parameter int EPOCH_W = 12,
  parameter int CYC_W   = EPOCH_W + 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic                     loadW,
  input  logic                     funcSel,
  input  logic signed [DATA_W-1:0] w0Init,
  input  logic signed [DATA_W-1:0] w1Init,
  input  logic signed [DATA_W-1:0] biasInit,
  input  logic signed [DATA_W-1:0] learnRate,
  input  logic signed [DATA_W-1:0] tolerance,
  input  logic [EPOCH_W-1:0]       maxEpochs,
  output logic                     done,
  output logic                     converged,
  output logic                     timeout,
  output logic signed [DATA_W-1:0] w0Out,
  output logic signed [DATA_W-1:0] w1Out,
  output logic signed [DATA_W-1:0] biasOut,
  output logic [EPOCH_W-1:0]       epochCount,
  output logic [CYC_W-1:0]         cycleCount
);

  dpCtrl_t dpCtl;
  logic    errOk;

  lms_neuron_ctrl #(
    .EPOCH_W(EPOCH_W),
    .CYC_W  (CYC_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .loadW     (loadW),
    .funcSel   (funcSel),
    .maxEpochs (maxEpochs),
    .errOk     (errOk),
    .ctl       (dpCtl),
    .done      (done),
    .converged (converged),
    .timeout   (timeout),
    .epochCount(epochCount),
    .cycleCount(cycleCount)
  );

  lms_neuron_dp #(
    .DATA_W(DATA_W),
    .FRAC_W(FRAC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (dpCtl),
    .w0Init   (w0Init),
    .w1Init   (w1Init),
    .biasInit (biasInit),
    .learnRate(learnRate),
    .tolerance(tolerance),
    .w0       (w0Out),
    .w1       (w1Out),
    .bias     (biasOut),
    .errOk    (errOk)
  );

endmodule

// File: rtl/lms_neuron_trainer_chk.sv
module lms_neuron_trainer_chk #(
  parameter int DATA_W  = 16,
  parameter int EPOCH_W = 12,
  parameter int CYC_W   = EPOCH_W + 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     start,
  input logic                     loadW,
  input logic [EPOCH_W-1:0]       maxEpochs,
  input logic                     done,
  input logic                     converged,
  input logic                     timeout,
  input logic signed [DATA_W-1:0] w0Out,
  input logic signed [DATA_W-1:0] w1Out,
  input logic signed [DATA_W-1:0] biasOut,
  input logic [EPOCH_W-1:0]       epochCount,
  input logic [CYC_W-1:0]         cycleCount
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(converged && timeout)); // R7

  AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (converged || timeout) |-> done); // R5

  AST_DONE_HAS_REASON: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (converged || timeout)); // R5

  AST_TIMEOUT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeout) |-> (epochCount >= maxEpochs)); // R6

  AST_CYCLES_PER_EPOCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (cycleCount == CYC_W'(epochCount) * CYC_W'(13))); // R8

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R9

  AST_WEIGHTS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start && !loadW) |=> ($stable(w0Out) && $stable(w1Out) && $stable(biasOut))); // R9

endmodule

bind lms_neuron_trainer lms_neuron_trainer_chk #(
  .DATA_W (DATA_W),
  .EPOCH_W(EPOCH_W),
  .CYC_W  (CYC_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .loadW     (loadW),
  .maxEpochs (maxEpochs),
  .done      (done),
  .converged (converged),
  .timeout   (timeout),
  .w0Out     (w0Out),
  .w1Out     (w1Out),
  .biasOut   (biasOut),
  .epochCount(epochCount),
  .cycleCount(cycleCount)
);

// File: tb/lms_neuron_trainer_tb.sv
module lms_neuron_trainer_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, loadW = 1'b0, funcSel = 1'b0;
  logic signed [15:0] w0Init = '0, w1Init = '0, biasInit = '0;
  logic signed [15:0] learnRate = '0, tolerance = '0;
  logic [11:0] maxEpochs = '0;
  logic done, converged, timeout;
  logic signed [15:0] w0Out, w1Out, biasOut;
  logic [11:0] epochCount;
  logic [15:0] cycleCount;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    int    w0, w1, b, ep, cyc;
    bit    conv, to;
  } expItem_t;

  expItem_t expQ[$];
  int mdlW0 = 0, mdlW1 = 0, mdlB = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lms_neuron_trainer u_dut (
    .clk(clk), .rstN(rstN), .start(start), .loadW(loadW), .funcSel(funcSel),
    .w0Init(w0Init), .w1Init(w1Init), .biasInit(biasInit),
    .learnRate(learnRate), .tolerance(tolerance), .maxEpochs(maxEpochs),
    .done(done), .converged(converged), .timeout(timeout),
    .w0Out(w0Out), .w1Out(w1Out), .biasOut(biasOut),
    .epochCount(epochCount), .cycleCount(cycleCount)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Reference training model built from R3..R7
  task automatic modelTrain(input int lr, input int tol, input int maxE, input bit fOr,
                            inout int w0, inout int w1, inout int b,
                            output bit conv, output bit to, output int ep);
    int lim;
    lim  = (maxE == 0) ? 1 : maxE;
    ep   = 0;
    conv = 0;
    to   = 0;
    while (!conv && !to) begin
      bit ok;
      ok = 1;
      for (int p = 0; p < 4; p++) begin
        int x0, x1, tgt, s, e, d, ae;
        x0  = (p >> 1) & 1;
        x1  = p & 1;
        tgt = fOr ? ((p != 0) ? 4096 : 0) : ((p == 3) ? 4096 : 0);
        s   = sat16(b + x0 * w0 + x1 * w1);
        e   = sat16(tgt - s);
        ae  = (e < 0) ? -e : e;
        if (!(ae < tol)) ok = 0;
        d   = sat16((lr * e + 2048) >>> 12);
        if (x0 != 0) w0 = sat16(w0 + d);
        if (x1 != 0) w1 = sat16(w1 + d);
        b = sat16(b + d);
      end
      ep++;
      if (ok) conv = 1;
      else if (ep >= lim) to = 1;
    end
  endtask

  // Driver: predicts, pushes to the scoreboard, then drives one training run
  task automatic runCase(input string tag, input bit doLoad, input int iw0, input int iw1,
                         input int ib, input int lr, input int tol, input int maxE,
                         input bit fOr, input bit disturb);
    expItem_t it;
    if (doLoad) begin
      mdlW0 = iw0; mdlW1 = iw1; mdlB = ib;
    end
    modelTrain(lr, tol, maxE, fOr, mdlW0, mdlW1, mdlB, it.conv, it.to, it.ep);
    it.tag = tag; it.w0 = mdlW0; it.w1 = mdlW1; it.b = mdlB; it.cyc = 13 * it.ep;
    expQ.push_back(it);
    @(negedge clk);
    w0Init = 16'(iw0); w1Init = 16'(iw1); biasInit = 16'(ib);
    learnRate = 16'(lr); tolerance = 16'(tol); maxEpochs = 12'(maxE);
    funcSel = fOr; loadW = doLoad; start = 1'b1;
    @(negedge clk);
    loadW = 1'b0; start = 1'b0;
    if (disturb) begin
      repeat (5) @(negedge clk);
      // R2: loads, restarts and mode changes mid-run must be ignored
      w0Init = 16'sh7000; w1Init = -16'sh7000; biasInit = 16'sh1234;
      loadW = 1'b1; start = 1'b1; funcSel = ~fOr;
      @(negedge clk);
      loadW = 1'b0; start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: on each rising done, compare against the oldest prediction
  initial begin
    bit prevDone;
    prevDone = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && done && !prevDone) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5: done rose with no prediction (actual 1 expected 0)");
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check({it.tag, " w0 R4"}, int'(w0Out), it.w0);
          check({it.tag, " w1 R4"}, int'(w1Out), it.w1);
          check({it.tag, " bias R4"}, int'(biasOut), it.b);
          check({it.tag, " converged R5"}, int'(converged), int'(it.conv));
          check({it.tag, " timeout R6"}, int'(timeout), int'(it.to));
          check({it.tag, " epochs R5"}, int'(epochCount), it.ep);
          check({it.tag, " cycles R8"}, int'(cycleCount), it.cyc);
        end
      end
      prevDone = done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 done", int'(done), 0);
    check("R1 converged", int'(converged), 0);
    check("R1 timeout", int'(timeout), 0);
    check("R1 w0", int'(w0Out), 0);
    check("R1 bias", int'(biasOut), 0);
    check("R1 epochCount", int'(epochCount), 0);
    check("R1 cycleCount", int'(cycleCount), 0);

    // R2: idle load without start
    w0Init = 16'sd1000; w1Init = -16'sd700; biasInit = 16'sd300; loadW = 1'b1;
    @(negedge clk);
    loadW = 1'b0;
    check("R2 load w0", int'(w0Out), 1000);
    check("R2 load w1", int'(w1Out), -700);
    check("R2 load bias", int'(biasOut), 300);
    check("R2 load no done", int'(done), 0);

    // R3/R4: one epoch from 0.5/0.7 against AND, zero tolerance
    runCase("R3 single epoch AND", 1, 2048, 2867, 0, 1024, 0, 1, 0, 0);
    // R5/R2: AND training to convergence with mid-run disturbance
    runCase("R5 AND converge", 1, 2048, 2867, 0, 410, 1638, 400, 0, 1);
    // R9: done holds and weights frozen while idle
    repeat (20) @(negedge clk);
    check("R9 done held", int'(done), 1);
    check("R9 w0 frozen", int'(w0Out), mdlW0);
    check("R9 bias frozen", int'(biasOut), mdlB);
    // R10: restart from held weights
    runCase("R10 restart", 0, 0, 0, 0, 410, 1638, 400, 0, 0);
    // R3 OR target with R6 timeout
    runCase("R6 OR timeout", 1, 0, 0, 0, 1024, 0, 5, 1, 0);
    runCase("R6 zero limit", 1, 512, -512, 256, 1024, 0, 0, 1, 0);
    // R7: convergence and limit on the same epoch
    runCase("R7 tie", 1, 0, 0, 0, 1024, 32767, 1, 0, 0);
    // R4 saturation, both directions
    runCase("R4 sat high", 1, 32767, 32767, 32767, 3686, 0, 3, 1, 0);
    runCase("R4 sat low", 1, -32768, -32768, -32768, 3686, 0, 3, 0, 0);
    // R2: load while done clears weights to the new values
    @(negedge clk);
    w0Init = 16'sd77; w1Init = 16'sd88; biasInit = -16'sd99; loadW = 1'b1;
    @(negedge clk);
    loadW = 1'b0;
    check("R2 load after done w0", int'(w0Out), 77);
    check("R2 load after done bias", int'(biasOut), -99);

    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R5: %0d predictions unmatched (actual %0d expected 0)", expQ.size(), expQ.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not end (actual hung expected done)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule